// File: doc/BRIEF.md
# Console UART Register Front End

This block is the byte-wide register file of a console serial port, reached through a simple memory-mapped bus with a 3-bit offset. One access per cycle is presented with a select, a write flag, the offset and write data. Read data is returned combinationally in the same cycle as the access. A data write emits the byte on a one-cycle transmit strobe. A data read takes one byte from a ready/valid receive source. The block keeps an interrupt-enable register, a line-control register with a divisor-access bit, a token modem-control register and two pending flags. From these it drives one level-sensitive interrupt line.

There is no shifter, so the line status always reports an empty transmitter. The transmit-empty interrupt is produced by a delay timer instead. Each transmit write starts the timer, and when the timer runs out the interrupt is raised, but only if the transmit interrupt is still enabled. While the divisor-access bit is set, offsets 0 and 1 reach a divisor that does not exist: writes there are dropped and reads return zero.

Top module: `console_uart_regs`

## Requirements
- R1: After reset, IER, LCR and MCR read 0, IIR reads 0, the interrupt line is low and no delay is running.
- R2: While LCR bit 7 is 1, writes to offset 0 or 1 are dropped: there is no transmit strobe and IER keeps its value. Reads of offset 0 or 1 return 0 and never take a receive byte.
- R3: A write to offset 0 with LCR bit 7 at 0 drives tx_valid_o high with tx_data_o equal to the write data in that same cycle. From the next cycle on, the interrupt line and the transmit-pending flag are cleared.
- R4: If IER bit 1 is set when a transmit write occurs, the interrupt rises exactly TX_DELAY cycles after that write's clock edge and the transmit-pending flag is set. A further transmit write restarts the count from the beginning.
- R5: A write to offset 1 (LCR bit 7 at 0) stores the byte, which then reads back. From the next cycle the interrupt line equals IER bit 1 OR (IER bit 0 AND rx_valid_i). Transmit-pending is cleared if bit 1 is 0. Receive-pending is cleared unless bit 0 is 1 and receive data is present.
- R6: Writing IER with bit 1 at 0 while a delay is running cancels the delay, so no interrupt and no transmit-pending appear at its end.
- R7: Offset 2 reads 1 while either pending flag is set and 0 otherwise. Writes to offset 2 have no effect.
- R8: A read of offset 0 (LCR bit 7 at 0) returns rx_data_i and pulses rx_ready_o if rx_valid_i is high, and otherwise returns 0. One cycle after the access the block examines rx_valid_i. If it is high, the interrupt is asserted. If it is low, the interrupt and receive-pending are cleared.
- R9: A rising edge of rx_valid_i while IER bit 0 is set raises the interrupt and receive-pending on the next clock. With IER bit 0 clear, the edge changes neither.
- R10: Offset 5 reads 0x60 (bit 6 transmitter empty, bit 5 holding register empty), with bit 0 equal to rx_valid_i. Offsets 6 and 7 read 0, and writes to offsets 5, 6 and 7 are discarded.
- R11: LCR at offset 3 stores and returns all 8 bits. Offset 4 reads the stored MCR. A write of 0x1A to offset 4 stores 0x9A, and any other value written there leaves MCR unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Receive byte available |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte taken this cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The following outputs are combinational and are sampled one time unit after the inputs are driven, within the access cycle itself: read data, the transmit strobe and the receive take. Register and interrupt effects of a write appear after the write's own clock edge and are sampled at the following falling edge. The receive follow-up after a data read lands one edge later, so that check waits one extra falling edge. The delayed transmit interrupt is checked on both sides of its boundary: low after TX_DELAY-1 edges and high after TX_DELAY edges, counted from the write edge. The same window is used after a restart and after a cancelling IER write.

// File: rtl/cu_pkg.sv
package cu_pkg;
    localparam int unsigned AW = 3;
    localparam int unsigned DW = 8;

    localparam logic [AW-1:0] OFS_DATA = 3'd0;
    localparam logic [AW-1:0] OFS_IER  = 3'd1;
    localparam logic [AW-1:0] OFS_IIR  = 3'd2;
    localparam logic [AW-1:0] OFS_LCR  = 3'd3;
    localparam logic [AW-1:0] OFS_MCR  = 3'd4;
    localparam logic [AW-1:0] OFS_LSR  = 3'd5;

    localparam int unsigned IER_RX_BIT  = 0;
    localparam int unsigned IER_TX_BIT  = 1;
    localparam int unsigned LCR_DIV_BIT = 7;
    localparam int unsigned LSR_DR_BIT  = 0;
    localparam int unsigned LSR_HE_BIT  = 5;
    localparam int unsigned LSR_TE_BIT  = 6;

    localparam logic [DW-1:0] MCR_KEY  = 8'h1A;
    localparam logic [DW-1:0] MCR_SAVE = 8'h9A;

    typedef struct packed {
        logic [DW-1:0] ier;
        logic [DW-1:0] lcr;
        logic [DW-1:0] mcr;
        logic          tx_pend;
        logic          rx_pend;
        logic          irq;
        logic          rx_seen;
        logic          pop_chk;
    } regs_t;
endpackage

// File: rtl/cu_tx_delay.sv
module cu_tx_delay #(
    parameter int unsigned DELAY = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic fire_o,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DELAY);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign fire_o = tmr_q.busy && (tmr_q.cnt == CW'(1));
    assign busy_o = tmr_q.busy;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (fire_o) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end
        if (cancel_i) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end
        if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R4: a running count stays inside its load window
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> (tmr_q.cnt != '0 && tmr_q.cnt <= LOAD));
    // R4: a start always leaves a full count behind
    a_r4_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tmr_q.busy && tmr_q.cnt == LOAD));
endmodule

// File: rtl/cu_rd_mux.sv
module cu_rd_mux
    import cu_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    input  logic          div_i,
    input  logic [DW-1:0] ier_i,
    input  logic [DW-1:0] lcr_i,
    input  logic [DW-1:0] mcr_i,
    input  logic          pend_i,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    output logic [DW-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_DATA: if (!div_i && rx_valid_i) rdata_o = rx_data_i;
            OFS_IER:  if (!div_i) rdata_o = ier_i;
            OFS_IIR:  rdata_o[0] = pend_i;
            OFS_LCR:  rdata_o = lcr_i;
            OFS_MCR:  rdata_o = mcr_i;
            OFS_LSR: begin
                rdata_o[LSR_TE_BIT] = 1'b1;
                rdata_o[LSR_HE_BIT] = 1'b1;
                rdata_o[LSR_DR_BIT] = rx_valid_i;
            end
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/console_uart_regs.sv
module console_uart_regs
    import cu_pkg::*;
#(
    parameter int unsigned TX_DELAY = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          tx_valid_o,
    output logic [DW-1:0] tx_data_o,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    output logic          rx_ready_o,
    output logic          irq_o
);
    regs_t reg_d, reg_q;

    logic div_on, wr_acc, rd_acc;
    logic thr_wr, ier_wr, rbr_rd;
    logic tmr_start, tmr_cancel, tmr_fire, tmr_busy;

    assign div_on     = reg_q.lcr[LCR_DIV_BIT];
    assign wr_acc     = bus_sel_i && bus_wr_i;
    assign rd_acc     = bus_sel_i && !bus_wr_i;
    assign thr_wr     = wr_acc && bus_addr_i == OFS_DATA && !div_on;
    assign ier_wr     = wr_acc && bus_addr_i == OFS_IER && !div_on;
    assign rbr_rd     = rd_acc && bus_addr_i == OFS_DATA && !div_on;
    assign tmr_start  = thr_wr && reg_q.ier[IER_TX_BIT];
    assign tmr_cancel = ier_wr && !bus_wdata_i[IER_TX_BIT];

    assign tx_valid_o = thr_wr;
    assign tx_data_o  = bus_wdata_i;
    assign rx_ready_o = rbr_rd && rx_valid_i;
    assign irq_o      = reg_q.irq;

    cu_tx_delay #(.DELAY(TX_DELAY)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .cancel_i (tmr_cancel),
        .fire_o   (tmr_fire),
        .busy_o   (tmr_busy)
    );

    cu_rd_mux u_rd_mux (
        .addr_i     (bus_addr_i),
        .div_i      (div_on),
        .ier_i      (reg_q.ier),
        .lcr_i      (reg_q.lcr),
        .mcr_i      (reg_q.mcr),
        .pend_i     (reg_q.tx_pend || reg_q.rx_pend),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .rdata_o    (bus_rdata_o)
    );

    always_comb begin
        reg_d         = reg_q;
        reg_d.rx_seen = rx_valid_i;
        reg_d.pop_chk = rbr_rd;

        // background events first; a bus access in the same cycle wins
        if (tmr_fire && reg_q.ier[IER_TX_BIT]) begin
            reg_d.irq     = 1'b1;
            reg_d.tx_pend = 1'b1;
        end
        if (rx_valid_i && !reg_q.rx_seen && reg_q.ier[IER_RX_BIT]) begin
            reg_d.irq     = 1'b1;
            reg_d.rx_pend = 1'b1;
        end
        if (reg_q.pop_chk) begin
            if (rx_valid_i) begin
                reg_d.irq = 1'b1;
            end else begin
                reg_d.irq     = 1'b0;
                reg_d.rx_pend = 1'b0;
            end
        end

        if (thr_wr) begin
            reg_d.irq     = 1'b0;
            reg_d.tx_pend = 1'b0;
        end
        if (ier_wr) begin
            reg_d.ier = bus_wdata_i;
            reg_d.irq = bus_wdata_i[IER_TX_BIT] ||
                        (bus_wdata_i[IER_RX_BIT] && rx_valid_i);
            if (!bus_wdata_i[IER_TX_BIT]) reg_d.tx_pend = 1'b0;
            if (!(bus_wdata_i[IER_RX_BIT] && rx_valid_i)) reg_d.rx_pend = 1'b0;
        end
        if (wr_acc && bus_addr_i == OFS_LCR) reg_d.lcr = bus_wdata_i;
        if (wr_acc && bus_addr_i == OFS_MCR && bus_wdata_i == MCR_KEY)
            reg_d.mcr = MCR_SAVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    // R3: a transmit write leaves the interrupt low on the next cycle
    a_r3_tx_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !irq_o);
    // R5: transmit-pending never survives with the transmit enable off
    a_r5_txpend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_q.ier[IER_TX_BIT] |-> !reg_q.tx_pend);
    // R6: the delay only runs while the transmit enable is on
    a_r6_delay_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> reg_q.ier[IER_TX_BIT]);
    // R2: divisor access blocks transmit and receive traffic
    a_r2_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        div_on |-> (!tx_valid_o && !rx_ready_o));
    // R11: MCR only ever holds its reset value or the stored token
    a_r11_mcr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.mcr == '0 || reg_q.mcr == MCR_SAVE);
    // R8: a receive take only happens when data is offered
    a_r8_take_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> rx_valid_i);
endmodule

// File: tb/console_uart_regs_bench.sv
module console_uart_regs_bench;
    localparam int unsigned DLY = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_valid, rx_ready, irq;
    logic [7:0] tx_data;
    logic       rx_valid;
    logic [7:0] rx_data;

    logic [7:0] rxq [0:15];
    int unsigned rx_head = 0, rx_tail = 0;
    assign rx_valid = (rx_head != rx_tail);
    assign rx_data  = rxq[rx_head[3:0]];

    int errors = 0, checks = 0;
    logic [7:0] m_lcr = 0, m_mcr = 0, m_ier = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (rx_ready) rx_head <= rx_head + 1;

    console_uart_regs #(.TX_DELAY(DLY)) u_console_uart_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
        .irq_o(irq));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                             output logic txv, output logic [7:0] txd);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        #1; txv = tx_valid; txd = tx_data;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        logic v; logic [7:0] x;
        bus_write(a, d, v, x);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic rdy);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        #1; d = rdata; rdy = rx_ready;
        @(negedge clk);
        sel = 0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rxq[rx_tail[3:0]] = b;
        rx_tail = rx_tail + 1;
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd1: return m_lcr[7] ? 8'h00 : m_ier;
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd5: return 8'h60 | {7'b0, rx_valid};
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic r; logic v; logic [7:0] x;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(3'd1, d, r); check("R1 IER", d, 8'h00);
        bus_read(3'd3, d, r); check("R1 LCR", d, 8'h00);
        bus_read(3'd4, d, r); check("R1 MCR", d, 8'h00);
        bus_read(3'd2, d, r); check("R1 IIR", d, 8'h00);

        // R3 transmit strobe without enable, no delay interrupt follows
        bus_write(3'd0, 8'hA5, v, x);
        check("R3 tx strobe", {7'b0, v}, 8'h01);
        check("R3 tx data", x, 8'hA5);
        check("R3 irq low", {7'b0, irq}, 8'h00);

        // R5 IER write with bit1 raises irq next cycle
        wr_reg(3'd1, 8'h02); m_ier = 8'h02;
        check("R5 irq from enable", {7'b0, irq}, 8'h01);
        bus_read(3'd1, d, r); check("R5 IER readback", d, 8'h02);

        // R3/R4 write clears irq, then exact boundary
        wr_reg(3'd0, 8'h11);
        check("R3 irq cleared", {7'b0, irq}, 8'h00);
        repeat (DLY - 1) @(negedge clk);
        check("R4 before boundary", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R4 at boundary", {7'b0, irq}, 8'h01);
        bus_read(3'd2, d, r); check("R4 IIR tx pending", d, 8'h01);

        // R4 restart
        wr_reg(3'd0, 8'h22);
        repeat (100) @(negedge clk);
        wr_reg(3'd0, 8'h33);
        repeat (DLY - 1) @(negedge clk);
        check("R4 restart not early", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R4 restart boundary", {7'b0, irq}, 8'h01);

        // R6 cancel during delay
        wr_reg(3'd0, 8'h44);
        repeat (50) @(negedge clk);
        wr_reg(3'd1, 8'h00); m_ier = 0;
        check("R6 irq off", {7'b0, irq}, 8'h00);
        repeat (DLY) @(negedge clk);
        check("R6 no late irq", {7'b0, irq}, 8'h00);
        bus_read(3'd2, d, r); check("R6 IIR clear", d, 8'h00);

        // R9 arrival with receive enable off
        push_rx(8'h5A);
        repeat (3) @(negedge clk);
        check("R9 no irq when disabled", {7'b0, irq}, 8'h00);
        bus_read(3'd2, d, r); check("R9 IIR stays 0", d, 8'h00);
        bus_read(3'd5, d, r); check("R10 LSR data ready", d, 8'h61);
        // R5 enable receive with data present
        wr_reg(3'd1, 8'h01); m_ier = 8'h01;
        check("R5 irq rx+data", {7'b0, irq}, 8'h01);
        bus_read(3'd0, d, r);
        check("R8 pop data", d, 8'h5A);
        check("R8 ready pulse", {7'b0, r}, 8'h01);
        @(negedge clk);
        check("R8 irq cleared when empty", {7'b0, irq}, 8'h00);
        bus_read(3'd5, d, r); check("R10 LSR empty", d, 8'h60);

        // R9 arrival with enable on, two bytes
        push_rx(8'hC1); push_rx(8'hC2);
        @(negedge clk);
        check("R9 irq on arrival", {7'b0, irq}, 8'h01);
        bus_read(3'd2, d, r); check("R9 IIR rx pending", d, 8'h01);
        bus_read(3'd0, d, r); check("R8 first byte", d, 8'hC1);
        @(negedge clk);
        check("R8 irq held, data left", {7'b0, irq}, 8'h01);
        bus_read(3'd0, d, r); check("R8 second byte", d, 8'hC2);
        @(negedge clk);
        check("R8 irq drop", {7'b0, irq}, 8'h00);
        bus_read(3'd2, d, r); check("R8 IIR clear", d, 8'h00);
        bus_read(3'd0, d, r);
        check("R8 empty read", d, 8'h00);
        check("R8 empty no ready", {7'b0, r}, 8'h00);

        // R2 divisor access
        wr_reg(3'd3, 8'h83); m_lcr = 8'h83;
        bus_write(3'd0, 8'h77, v, x);
        check("R2 no tx strobe", {7'b0, v}, 8'h00);
        wr_reg(3'd1, 8'hFF);
        bus_read(3'd1, d, r); check("R2 offset1 reads 0", d, 8'h00);
        push_rx(8'h99);
        bus_read(3'd0, d, r);
        check("R2 offset0 reads 0", d, 8'h00);
        check("R2 no take", {7'b0, r}, 8'h00);
        wr_reg(3'd3, 8'h03); m_lcr = 8'h03;
        bus_read(3'd1, d, r); check("R2 IER untouched", d, 8'h01);
        bus_read(3'd0, d, r); check("R8 held byte", d, 8'h99);
        wr_reg(3'd1, 8'h00); m_ier = 0;
        @(negedge clk);

        // R7 FCR write ignored, R11 MCR key
        wr_reg(3'd2, 8'hFF);
        bus_read(3'd2, d, r); check("R7 FCR ignored", d, 8'h00);
        wr_reg(3'd4, 8'h1A); m_mcr = 8'h9A;
        bus_read(3'd4, d, r); check("R11 MCR key", d, 8'h9A);

        // random register traffic against the model (R10, R11)
        for (int i = 0; i < 200; i++) begin
            int op;
            logic [7:0] val;
            logic [2:0] a;
            op = $urandom % 4;
            val = 8'($urandom);
            case (op)
                0: begin wr_reg(3'd3, val); m_lcr = val; end
                1: begin
                    if ($urandom % 3 == 0) val = 8'h1A;
                    wr_reg(3'd4, val);
                    if (val == 8'h1A) m_mcr = 8'h9A;
                end
                2: begin
                    a = 3'd5 + 3'($urandom % 3);
                    if (m_lcr[7] && ($urandom % 2 == 0)) a = 3'd1;
                    wr_reg(a, val);
                end
                default: begin
                    a = 3'd1 + 3'($urandom % 7);
                    bus_read(a, d, r);
                    check(a == 3'd3 ? "R11 LCR random" :
                          (a == 3'd4 ? "R11 MCR random" : "R10 random read"),
                          d, exp_rd(a));
                end
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule